// File: doc/BRIEF.md
# Display Memory Write-Address Walker

This block produces the write position for a display memory laid out as a grid of columns (X) by byte-rows (Y), 84 by 6 with the default parameters. The host sets the column and the byte-row with two independent load strobes. Each time a display byte is written, the host pulses `advance` and the walker moves to the next cell. The next cell depends on the traversal order chosen by `vert_mode`. In column-first order the row index runs fastest and carries into the column. In row-first order the column index runs fastest and carries into the row. Neither limit needs to be a power of two.

Alongside the two coordinates, the block gives a flat memory address equal to `Y * X_LIMIT + X`, so a linear RAM can be driven directly. All pins are plain control and status signals. The block has no data stream at its edge, so there is no valid/ready pairing and no back-pressure: `advance` is taken as a single-cycle command in any cycle it is high. Loaded values above the legal range saturate at the top cell index, so the coordinates always stay legal.

Top module: `disp_addr_walker`

## Requirements
- R1: While `rst_n` is low, and after it rises, `cur_x`, `cur_y` and `ram_addr` are 0 until the first load or advance.
- R2: A cycle with `ld_x` high and `ld_x_val` below X_LIMIT sets `cur_x` to `ld_x_val` at the next clock edge.
- R3: A cycle with `ld_y` high and `ld_y_val` below Y_LIMIT sets `cur_y` to `ld_y_val` at the next clock edge.
- R4: A load value at or above its axis limit sets that coordinate to the limit minus one (83 for X, 5 for Y by default).
- R5: With `vert_mode` = 1, `advance` high and Y below its maximum, Y increments by one and X holds.
- R6: With `vert_mode` = 1, `advance` high and Y at its maximum, Y returns to 0 and X increments by one.
- R7: With `vert_mode` = 0, `advance` high and X below its maximum, X increments by one and Y holds.
- R8: With `vert_mode` = 0, `advance` high and X at its maximum, X returns to 0 and Y increments by one.
- R9: Advancing from X = 83, Y = 5 goes to X = 0, Y = 0 in either order.
- R10: In a cycle where either load strobe is high, `advance` has no effect. Only the loaded axis changes, and the other axis holds.
- R11: `ram_addr` equals `cur_y * 84 + cur_x` in the same cycle. In row-first order, each advance therefore raises it by exactly one, and it wraps from 503 to 0.
- R12: With no load and no advance, X and Y hold their values whatever `vert_mode` does.
- R13: `cur_x` never exceeds 83 and `cur_y` never exceeds 5.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ld_x | input | 1 | Load the column index from `ld_x_val` |
| ld_x_val | input | 7 | Column value to load (clamped) |
| ld_y | input | 1 | Load the byte-row index from `ld_y_val` |
| ld_y_val | input | 3 | Byte-row value to load (clamped) |
| vert_mode | input | 1 | Traversal order: 1 = row index fastest, 0 = column index fastest |
| advance | input | 1 | Step to the next cell (one pulse per written byte) |
| cur_x | output | 7 | Current column index |
| cur_y | output | 3 | Current byte-row index |
| ram_addr | output | 9 | Flat address `cur_y * X_LIMIT + cur_x` |

## Verification
The bench builds the walker with its default limits of 84 and 6. These sizes put both non-power-of-two wraps and the combined corner wrap within a short run. Because the whole grid is only 504 cells, a full pass in each traversal order finishes in a few hundred cycles. That pass reaches every carry, and in row-first order it checks that the flat address rises by one per byte across all 504 cells. With a 7-bit X field and a 3-bit Y field, the load values 84 to 127 and 6 to 7 can be driven, which exercises the clamping.

// File: rtl/disp_walk_pkg.sv
package disp_walk_pkg;

  typedef enum logic {
    ORD_ROW_FIRST = 1'b0,
    ORD_COL_FIRST = 1'b1
  } walk_order_e;

  typedef struct packed {
    logic step_x;
    logic step_y;
  } step_req_t;

endpackage

// File: rtl/dwalk_load_clamp.sv
module dwalk_load_clamp #(
  parameter int LIMIT = 84,
  parameter int W     = 7
) (
  input  logic [W-1:0] raw_val,
  output logic [W-1:0] legal_val
);
  localparam logic [W-1:0] TOP = W'(LIMIT - 1);

  always_comb begin
    if (raw_val > TOP) legal_val = TOP;
    else               legal_val = raw_val;
  end
endmodule

// File: rtl/dwalk_wrap_stage.sv
module dwalk_wrap_stage #(
  parameter int LIMIT = 84,
  parameter int W     = 7
) (
  input  logic [W-1:0] cur,
  input  logic         step_en,
  output logic [W-1:0] nxt,
  output logic         at_top
);
  localparam logic [W-1:0] TOP = W'(LIMIT - 1);

  assign at_top = (cur == TOP);

  always_comb begin
    if (!step_en)    nxt = cur;
    else if (at_top) nxt = '0;
    else             nxt = cur + W'(1);
  end
endmodule

// File: rtl/dwalk_linear_map.sv
module dwalk_linear_map #(
  parameter int X_LIMIT = 84,
  parameter int XW      = 7,
  parameter int YW      = 3,
  parameter int AW      = 9
) (
  input  logic [XW-1:0] x_idx,
  input  logic [YW-1:0] y_idx,
  output logic [AW-1:0] flat
);
  localparam logic [AW-1:0] ROW_SPAN = AW'(X_LIMIT);

  always_comb flat = AW'(y_idx) * ROW_SPAN + AW'(x_idx);
endmodule

// File: rtl/disp_addr_walker.sv
module disp_addr_walker #(
  parameter int X_LIMIT = 84,
  parameter int Y_LIMIT = 6,
  parameter int XW      = (X_LIMIT > 1) ? $clog2(X_LIMIT) : 1,
  parameter int YW      = (Y_LIMIT > 1) ? $clog2(Y_LIMIT) : 1,
  parameter int AW      = $clog2(X_LIMIT * Y_LIMIT)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_x,
  input  logic [XW-1:0] ld_x_val,
  input  logic          ld_y,
  input  logic [YW-1:0] ld_y_val,
  input  logic          vert_mode,
  input  logic          advance,
  output logic [XW-1:0] cur_x,
  output logic [YW-1:0] cur_y,
  output logic [AW-1:0] ram_addr
);
  import disp_walk_pkg::*;

  logic [XW-1:0] x_q, x_step, x_load;
  logic [YW-1:0] y_q, y_step, y_load;
  logic          x_top, y_top, any_load;
  walk_order_e   order;
  step_req_t     req;

  assign order    = walk_order_e'(vert_mode);
  assign any_load = ld_x | ld_y;

  // The fast axis always moves on an advance; the slow axis only on the fast axis's wrap.
  always_comb begin
    req = '0;
    if (advance && !any_load) begin
      if (order == ORD_COL_FIRST) begin
        req.step_y = 1'b1;
        req.step_x = y_top;
      end else begin
        req.step_x = 1'b1;
        req.step_y = x_top;
      end
    end
  end

  dwalk_load_clamp #(.LIMIT(X_LIMIT), .W(XW)) u_clamp_x (
    .raw_val(ld_x_val), .legal_val(x_load)
  );
  dwalk_load_clamp #(.LIMIT(Y_LIMIT), .W(YW)) u_clamp_y (
    .raw_val(ld_y_val), .legal_val(y_load)
  );

  dwalk_wrap_stage #(.LIMIT(X_LIMIT), .W(XW)) u_stage_x (
    .cur(x_q), .step_en(req.step_x), .nxt(x_step), .at_top(x_top)
  );
  dwalk_wrap_stage #(.LIMIT(Y_LIMIT), .W(YW)) u_stage_y (
    .cur(y_q), .step_en(req.step_y), .nxt(y_step), .at_top(y_top)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x_q <= '0;
      y_q <= '0;
    end else if (any_load) begin
      if (ld_x) x_q <= x_load;
      if (ld_y) y_q <= y_load;
    end else begin
      x_q <= x_step;
      y_q <= y_step;
    end
  end

  dwalk_linear_map #(.X_LIMIT(X_LIMIT), .XW(XW), .YW(YW), .AW(AW)) u_map (
    .x_idx(x_q), .y_idx(y_q), .flat(ram_addr)
  );

  assign cur_x = x_q;
  assign cur_y = y_q;
endmodule

// File: rtl/dwalk_checker.sv
module dwalk_checker #(
  parameter int X_LIMIT = 84,
  parameter int Y_LIMIT = 6,
  parameter int XW      = 7,
  parameter int YW      = 3,
  parameter int AW      = 9
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ld_x,
  input logic [XW-1:0] ld_x_val,
  input logic          ld_y,
  input logic [YW-1:0] ld_y_val,
  input logic          vert_mode,
  input logic          advance,
  input logic [XW-1:0] cur_x,
  input logic [YW-1:0] cur_y,
  input logic [AW-1:0] ram_addr
);
  localparam logic [XW-1:0] XT = XW'(X_LIMIT - 1);
  localparam logic [YW-1:0] YT = YW'(Y_LIMIT - 1);
  localparam logic [AW-1:0] AT = AW'(X_LIMIT * Y_LIMIT - 1);

  logic idle_c, adv_c;
  assign idle_c = !ld_x && !ld_y && !advance;
  assign adv_c  = advance && !ld_x && !ld_y;

  p_range_r13: assert property (@(posedge clk) disable iff (!rst_n)
    cur_x <= XT && cur_y <= YT);

  p_load_x_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ld_x && ld_x_val <= XT |=> cur_x == $past(ld_x_val));

  p_load_y_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ld_y && ld_y_val <= YT |=> cur_y == $past(ld_y_val));

  p_clamp_x_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ld_x && ld_x_val > XT |=> cur_x == XT);

  p_vert_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    adv_c && vert_mode && cur_y != YT |=> cur_y == $past(cur_y) + YW'(1) && $stable(cur_x));

  p_horiz_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    adv_c && !vert_mode && cur_x != XT |=> cur_x == $past(cur_x) + XW'(1) && $stable(cur_y));

  p_corner_r9: assert property (@(posedge clk) disable iff (!rst_n)
    adv_c && cur_x == XT && cur_y == YT |=> cur_x == '0 && cur_y == '0);

  p_load_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ld_x && !ld_y && advance |=> $stable(cur_y));

  p_flat_step_r11: assert property (@(posedge clk) disable iff (!rst_n)
    adv_c && !vert_mode && ram_addr != AT |=> ram_addr == $past(ram_addr) + AW'(1));

  p_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    idle_c |=> $stable(cur_x) && $stable(cur_y));
endmodule

bind disp_addr_walker dwalk_checker #(
  .X_LIMIT(X_LIMIT), .Y_LIMIT(Y_LIMIT), .XW(XW), .YW(YW), .AW(AW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ld_x(ld_x), .ld_x_val(ld_x_val), .ld_y(ld_y),
  .ld_y_val(ld_y_val), .vert_mode(vert_mode), .advance(advance),
  .cur_x(cur_x), .cur_y(cur_y), .ram_addr(ram_addr)
);

// File: tb/sim_disp_addr_walker.sv
`timescale 1ns/1ps
module sim_disp_addr_walker;
  localparam int XL = 84;
  localparam int YL = 6;
  localparam int NV = 20;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ld_x = 1'b0, ld_y = 1'b0, vert_mode = 1'b0, advance = 1'b0;
  logic [6:0] ld_x_val = '0;
  logic [2:0] ld_y_val = '0;
  logic [6:0] cur_x;
  logic [2:0] cur_y;
  logic [8:0] ram_addr;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  disp_addr_walker u0 (
    .clk(clk), .rst_n(rst_n), .ld_x(ld_x), .ld_x_val(ld_x_val), .ld_y(ld_y),
    .ld_y_val(ld_y_val), .vert_mode(vert_mode), .advance(advance),
    .cur_x(cur_x), .cur_y(cur_y), .ram_addr(ram_addr)
  );

  // Vector layout: [23] ldx [22:16] xval [15] ldy [14:12] yval [11] adv [10] vert [9:3] exp_x [2:0] exp_y
  localparam logic [23:0] VEC [NV] = '{
    {1'b1, 7'd10,  1'b0, 3'd0, 1'b0, 1'b0, 7'd10, 3'd0}, // R2
    {1'b0, 7'd0,   1'b1, 3'd3, 1'b0, 1'b0, 7'd10, 3'd3}, // R3
    {1'b0, 7'd0,   1'b0, 3'd0, 1'b1, 1'b1, 7'd10, 3'd4}, // R5
    {1'b0, 7'd0,   1'b0, 3'd0, 1'b1, 1'b1, 7'd10, 3'd5}, // R5
    {1'b0, 7'd0,   1'b0, 3'd0, 1'b1, 1'b1, 7'd11, 3'd0}, // R6
    {1'b0, 7'd0,   1'b0, 3'd0, 1'b1, 1'b0, 7'd12, 3'd0}, // R7
    {1'b1, 7'd83,  1'b0, 3'd0, 1'b0, 1'b0, 7'd83, 3'd0}, // R2
    {1'b0, 7'd0,   1'b0, 3'd0, 1'b1, 1'b0, 7'd0,  3'd1}, // R8
    {1'b1, 7'd120, 1'b0, 3'd0, 1'b0, 1'b0, 7'd83, 3'd1}, // R4
    {1'b0, 7'd0,   1'b1, 3'd7, 1'b0, 1'b0, 7'd83, 3'd5}, // R4
    {1'b0, 7'd0,   1'b0, 3'd0, 1'b1, 1'b0, 7'd0,  3'd0}, // R9
    {1'b1, 7'd83,  1'b1, 3'd5, 1'b0, 1'b0, 7'd83, 3'd5}, // R2 R3
    {1'b0, 7'd0,   1'b0, 3'd0, 1'b1, 1'b1, 7'd0,  3'd0}, // R9
    {1'b1, 7'd5,   1'b0, 3'd0, 1'b1, 1'b0, 7'd5,  3'd0}, // R10
    {1'b0, 7'd0,   1'b0, 3'd0, 1'b0, 1'b1, 7'd5,  3'd0}, // R12
    {1'b0, 7'd0,   1'b1, 3'd2, 1'b1, 1'b1, 7'd5,  3'd2}, // R10
    {1'b0, 7'd0,   1'b0, 3'd0, 1'b1, 1'b0, 7'd6,  3'd2}, // R7
    {1'b1, 7'd127, 1'b1, 3'd4, 1'b0, 1'b1, 7'd83, 3'd4}, // R4 R3
    {1'b0, 7'd0,   1'b0, 3'd0, 1'b1, 1'b1, 7'd83, 3'd5}, // R5
    {1'b0, 7'd0,   1'b0, 3'd0, 1'b0, 1'b0, 7'd83, 3'd5}  // R12
  };

  task automatic check_pos(input string req, input int ex, input int ey);
    checks++;
    if (int'(cur_x) != ex || int'(cur_y) != ey || int'(ram_addr) != ey * XL + ex) begin
      fails++;
      $display("FAIL %s: got x=%0d y=%0d addr=%0d, expected x=%0d y=%0d addr=%0d",
               req, cur_x, cur_y, ram_addr, ex, ey, ey * XL + ex);
    end
  endtask

  // Inputs are applied at a falling edge, held across one rising edge, and read back at the next falling edge.
  task automatic step(input logic lx, input logic [6:0] xv, input logic ly,
                      input logic [2:0] yv, input logic adv, input logic vm);
    ld_x = lx; ld_x_val = xv; ld_y = ly; ld_y_val = yv; advance = adv; vert_mode = vm;
    @(negedge clk);
    ld_x = 1'b0; ld_y = 1'b0; advance = 1'b0;
  endtask

  initial begin
    repeat (500000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int ex, ey;
    repeat (3) @(negedge clk);
    check_pos("R1 in reset", 0, 0);
    rst_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check_pos("R1 after reset", 0, 0);

    for (int i = 0; i < NV; i++) begin
      logic [23:0] v;
      v = VEC[i];
      step(v[23], v[22:16], v[15], v[14:12], v[11], v[10]);
      check_pos($sformatf("R11 vector %0d", i), int'(v[9:3]), int'(v[2:0]));
    end

    // Row-first full pass from the origin: flat address counts 0..503 and wraps (R7 R8 R11).
    step(1'b1, 7'd0, 1'b1, 3'd0, 1'b0, 1'b0);
    check_pos("R2 origin", 0, 0);
    for (int k = 1; k <= XL * YL; k++) begin
      step(1'b0, 7'd0, 1'b0, 3'd0, 1'b1, 1'b0);
      ex = k % XL;
      ey = (k / XL) % YL;
      check_pos("R8 row-first sweep", ex, ey);
    end

    // Column-first full pass: row index fastest, carry into column (R5 R6 R13).
    ex = 0; ey = 0;
    for (int k = 1; k <= XL * YL; k++) begin
      step(1'b0, 7'd0, 1'b0, 3'd0, 1'b1, 1'b1);
      if (ey == YL - 1) begin
        ey = 0;
        ex = (ex == XL - 1) ? 0 : ex + 1;
      end else begin
        ey = ey + 1;
      end
      check_pos("R6 col-first sweep", ex, ey);
    end

    // Reset in the middle of a run clears both axes (R1).
    step(1'b1, 7'd40, 1'b1, 3'd3, 1'b0, 1'b0);
    check_pos("R3 before reset", 40, 3);
    rst_n = 1'b0;
    @(negedge clk);
    check_pos("R1 mid-run reset", 0, 0);
    rst_n = 1'b1;
    @(negedge clk);
    step(1'b0, 7'd0, 1'b0, 3'd0, 1'b0, 1'b1);
    check_pos("R12 idle after reset", 0, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule